// File: doc/BRIEF.md
# Hierarchical Bitmask Intersection Lane

This block is a single compute lane that intersects two set-valued domains. A domain is a three-level summary tree of bitmask words: one top word, a row of middle words under it, and a row of bottom (leaf) words under each middle word. A set bit at an upper level promises that the word beneath it holds at least one set bit; a clear bit means the whole subtree is empty. The lane holds several domains in its own storage. A host-side write port fills them and a read port inspects them. The host starts an operation with two operand IDs and a result ID.

The lane ANDs the two top words and visits only the surviving bits, lowest index first. Inside each visited subtree it ANDs the middle words and descends only into surviving bits. Each visited leaf pair is ANDed and the result is stored. Leaf results that come out zero prune their middle bit, and middle words that come out zero prune their top bit, so the stored result stays canonical. Empty subtrees cost no leaf visits and no leaf writes. A one-cycle done pulse reports the number of surviving values and whether the result is empty. The lane shares nothing with its neighbours, so any number of copies can run side by side. With `FAN` = 64 the universe is 262,144 values; the default build uses a smaller fan-out.

Top module: `hbl_lane`

## Requirements
- R1: During and right after synchronous active-low reset, `busy`, `done`, `done_empty` and `done_count` are all 0.
- R2: For every top index m and leaf index l whose bits survive both the top-word AND and the middle-word AND, result leaf {m,l} (index m*FAN+l) equals the AND of the two operand leaves at that index.
- R3: For every m set in the AND of the operand top words, result middle word m equals the AND of the operand middle words with each bit cleared whose leaf result is zero. Result top bit m is set exactly when that middle word is nonzero.
- R4: No result middle word is written for an m outside the top-word AND, and no result leaf is written outside the visited positions. Those words keep their previous contents.
- R5: `done` is high for exactly one cycle per accepted start. With it, `done_count` equals the total number of set bits in the result leaves, and `done_empty` is 1 exactly when the result top word is zero.
- R6: A `start` seen while `busy` is high is ignored: it neither changes the running operation nor produces an extra `done`.
- R7: Host writes presented while `busy` is high are dropped.
- R8: `done` rises exactly 2 + Σ(2 + k_m) rising edges after the edge that accepts `start`. The sum runs over the set bits m of the top-word AND, and k_m is the number of set bits in the AND of the operand middle words m.
- R9: The result ID may equal an operand ID, and the result is then still as given by R2 to R4.
- R10: Level code 0 selects the top word, 1 a middle word (index in the low log2(FAN) bits of the index) and 2 a leaf (index {m,l}). `rd_data` shows the word selected by the read inputs one clock edge after they are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_level | input | 2 | Host write level code (0 top, 1 middle, 2 leaf) |
| wr_dom | input | log2(NDOM) | Host write domain ID |
| wr_idx | input | 2*log2(FAN) | Host write word index |
| wr_data | input | FAN | Host write data |
| rd_level | input | 2 | Host read level code |
| rd_dom | input | log2(NDOM) | Host read domain ID |
| rd_idx | input | 2*log2(FAN) | Host read word index |
| rd_data | output | FAN | Registered host read data |
| start | input | 1 | Start request |
| op_a | input | log2(NDOM) | First operand domain ID |
| op_b | input | log2(NDOM) | Second operand domain ID |
| op_r | input | log2(NDOM) | Result domain ID |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | 3*log2(FAN)+1 | Number of values in the result |
| done_empty | output | 1 | Result is the empty set |

## Verification
The hardest case to reach is the cascade in which the leaf ANDs under a shared middle bit all come out zero. The lane must then clear that middle bit and then the top bit above it, while the operand top and middle words still overlap. The bench builds this on purpose with operand leaves that sit under the same bits but hold disjoint patterns. Random stimulus with very sparse leaf words (three random words ANDed) makes partial pruning happen often. Running starts and host writes are injected while the lane is busy. Every result word is then read back through the read port and compared with a model that tracks the prior contents of the storage, so stray writes to skipped subtrees would show up.

// File: rtl/hbl_pkg.sv
// Package: shared level codes and walker states for the hierarchical
// bitmask intersection lane. Assumes level codes are two bits wide.
package hbl_pkg;

    // Level codes used on the host and engine write/read ports
    localparam logic [1:0] LVL_ROOT = 2'd0;
    localparam logic [1:0] LVL_MID  = 2'd1;
    localparam logic [1:0] LVL_LEAF = 2'd2;

    // Walker states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROOT = 2'd1,
        ST_MID  = 2'd2,
        ST_LEAF = 2'd3
    } walk_state_t;

endpackage

// File: rtl/hbl_ffs.sv
// Module: lowest-set-bit finder. Returns the index of the lowest set bit of
// vec and a flag telling whether any bit is set. Assumes W is a power of 2.
module hbl_ffs #(
    parameter int W = 16
) (
    input  logic [W-1:0]         vec,
    output logic [$clog2(W)-1:0] idx,
    output logic                 any
);
    localparam int IW = $clog2(W);

    // Scan from the top so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
        any = |vec;
    end
endmodule

// File: rtl/hbl_popcnt.sv
// Module: population count of one word. Purely combinational.
module hbl_popcnt #(
    parameter int W = 16
) (
    input  logic [W-1:0]           vec,
    output logic [$clog2(W+1)-1:0] cnt
);
    localparam int CW = $clog2(W + 1);

    // Sum the bits of the word
    always_comb begin
        cnt = '0;
        for (int i = 0; i < W; i++) begin
            cnt = cnt + CW'(vec[i]);
        end
    end
endmodule

// File: rtl/hbl_store.sv
// Module: lane-local domain storage. Holds NDOM domains, each with one top
// word, FAN middle words and FAN*FAN leaf words. Two combinational engine
// read ports (operands A and B), one registered host read port, and a
// single write port shared by engine and host. The engine owns the write
// port while busy; host writes are dropped then. Assumes NDOM and FAN are
// powers of 2 and NDOM >= 2. Storage is not reset.
module hbl_store #(
    parameter int FAN  = 16,
    parameter int NDOM = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      busy,
    // host write
    input  logic                      h_we,
    input  logic [1:0]                h_lvl,
    input  logic [$clog2(NDOM)-1:0]   h_dom,
    input  logic [2*$clog2(FAN)-1:0]  h_idx,
    input  logic [FAN-1:0]            h_data,
    // host read
    input  logic [1:0]                h_rlvl,
    input  logic [$clog2(NDOM)-1:0]   h_rdom,
    input  logic [2*$clog2(FAN)-1:0]  h_ridx,
    output logic [FAN-1:0]            h_rdata,
    // engine reads
    input  logic [$clog2(NDOM)-1:0]   e_dom_a,
    input  logic [$clog2(NDOM)-1:0]   e_dom_b,
    input  logic [$clog2(FAN)-1:0]    e_mid_idx,
    input  logic [$clog2(FAN)-1:0]    e_leaf_idx,
    output logic [FAN-1:0]            root_a,
    output logic [FAN-1:0]            root_b,
    output logic [FAN-1:0]            mid_a,
    output logic [FAN-1:0]            mid_b,
    output logic [FAN-1:0]            leaf_a,
    output logic [FAN-1:0]            leaf_b,
    // engine write
    input  logic                      e_we,
    input  logic [1:0]                e_lvl,
    input  logic [$clog2(NDOM)-1:0]   e_dom,
    input  logic [2*$clog2(FAN)-1:0]  e_idx,
    input  logic [FAN-1:0]            e_data
);
    import hbl_pkg::*;

    localparam int FW   = $clog2(FAN);
    localparam int DW   = $clog2(NDOM);
    localparam int IW   = 2 * FW;
    localparam int NMID = NDOM * FAN;
    localparam int NLF  = NDOM * FAN * FAN;

    logic [FAN-1:0] root_mem [NDOM];
    logic [FAN-1:0] mid_mem  [NMID];
    logic [FAN-1:0] leaf_mem [NLF];

    logic           w_en;
    logic [1:0]     w_lvl;
    logic [DW-1:0]  w_dom;
    logic [IW-1:0]  w_idx;
    logic [FAN-1:0] w_data;

    // Write port arbitration: engine while busy, host otherwise
    always_comb begin
        if (busy) begin
            w_en   = e_we;
            w_lvl  = e_lvl;
            w_dom  = e_dom;
            w_idx  = e_idx;
            w_data = e_data;
        end else begin
            w_en   = h_we;
            w_lvl  = h_lvl;
            w_dom  = h_dom;
            w_idx  = h_idx;
            w_data = h_data;
        end
    end

    // Storage update through the single write port
    always_ff @(posedge clk) begin
        if (w_en) begin
            case (w_lvl)
                LVL_ROOT: root_mem[w_dom]                 <= w_data;
                LVL_MID:  mid_mem[{w_dom, w_idx[FW-1:0]}] <= w_data;
                LVL_LEAF: leaf_mem[{w_dom, w_idx}]        <= w_data;
                default:  ;
            endcase
        end
    end

    // Engine operand reads, combinational
    always_comb begin
        root_a = root_mem[e_dom_a];
        root_b = root_mem[e_dom_b];
        mid_a  = mid_mem[{e_dom_a, e_mid_idx}];
        mid_b  = mid_mem[{e_dom_b, e_mid_idx}];
        leaf_a = leaf_mem[{e_dom_a, e_mid_idx, e_leaf_idx}];
        leaf_b = leaf_mem[{e_dom_b, e_mid_idx, e_leaf_idx}];
    end

    // Registered host read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_rdata <= '0;
        end else begin
            case (h_rlvl)
                LVL_ROOT: h_rdata <= root_mem[h_rdom];
                LVL_MID:  h_rdata <= mid_mem[{h_rdom, h_ridx[FW-1:0]}];
                LVL_LEAF: h_rdata <= leaf_mem[{h_rdom, h_ridx}];
                default:  h_rdata <= '0;
            endcase
        end
    end

    // The engine writes only while it owns the lane
    p_eng_write_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        e_we |-> busy);

endmodule

// File: rtl/hbl_walker.sv
// Module: traversal engine. Accepts a start with operand/result IDs, ANDs
// the top words, visits surviving top bits lowest first, ANDs the middle
// words, visits surviving middle bits lowest first, ANDs the leaves and
// writes them. It prunes zero leaves from the middle word and zero middle
// words from the top word, writes the top word last and pulses done with
// the value count. Assumes the storage reads are combinational.
module hbl_walker #(
    parameter int FAN  = 16,
    parameter int NDOM = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [$clog2(NDOM)-1:0]   op_a,
    input  logic [$clog2(NDOM)-1:0]   op_b,
    input  logic [$clog2(NDOM)-1:0]   op_r,
    output logic                      busy,
    output logic                      done,
    output logic [3*$clog2(FAN):0]    done_count,
    output logic                      done_empty,
    // storage reads
    output logic [$clog2(NDOM)-1:0]   dom_a,
    output logic [$clog2(NDOM)-1:0]   dom_b,
    output logic [$clog2(FAN)-1:0]    mid_idx,
    output logic [$clog2(FAN)-1:0]    leaf_idx,
    input  logic [FAN-1:0]            root_a,
    input  logic [FAN-1:0]            root_b,
    input  logic [FAN-1:0]            mid_a,
    input  logic [FAN-1:0]            mid_b,
    input  logic [FAN-1:0]            leaf_a,
    input  logic [FAN-1:0]            leaf_b,
    // storage write
    output logic                      e_we,
    output logic [1:0]                e_lvl,
    output logic [$clog2(NDOM)-1:0]   e_dom,
    output logic [2*$clog2(FAN)-1:0]  e_idx,
    output logic [FAN-1:0]            e_data
);
    import hbl_pkg::*;

    localparam int FW = $clog2(FAN);
    localparam int DW = $clog2(NDOM);
    localparam int IW = 2 * FW;
    localparam int CW = 3 * FW + 1;
    localparam int PW = $clog2(FAN + 1);

    walk_state_t    state;
    logic [DW-1:0]  a_q, b_q, r_q;
    logic [FAN-1:0] root_rem, root_res;
    logic [FAN-1:0] mid_rem, mid_res;
    logic [FW-1:0]  cur_m;
    logic [CW-1:0]  cnt;

    logic [FW-1:0]  m_pick, l_pick;
    logic           m_any, l_any;
    logic [FAN-1:0] leaf_and;
    logic [PW-1:0]  leaf_pc;

    hbl_ffs #(.W(FAN)) u_ffs_root (.vec(root_rem), .idx(m_pick), .any(m_any));
    hbl_ffs #(.W(FAN)) u_ffs_mid  (.vec(mid_rem),  .idx(l_pick), .any(l_any));
    hbl_popcnt #(.W(FAN)) u_pc (.vec(leaf_and), .cnt(leaf_pc));

    assign busy     = (state != ST_IDLE);
    assign dom_a    = a_q;
    assign dom_b    = b_q;
    assign mid_idx  = (state == ST_MID) ? m_pick : cur_m;
    assign leaf_idx = l_pick;
    assign leaf_and = leaf_a & leaf_b;

    // Engine write request: leaf per visit, middle word on subtree exit,
    // top word at the end
    always_comb begin
        e_we   = 1'b0;
        e_lvl  = LVL_ROOT;
        e_dom  = r_q;
        e_idx  = '0;
        e_data = '0;
        if (state == ST_LEAF && l_any) begin
            e_we   = 1'b1;
            e_lvl  = LVL_LEAF;
            e_idx  = {cur_m, l_pick};
            e_data = leaf_and;
        end else if (state == ST_LEAF) begin
            e_we   = 1'b1;
            e_lvl  = LVL_MID;
            e_idx  = {{FW{1'b0}}, cur_m};
            e_data = mid_res;
        end else if (state == ST_MID && !m_any) begin
            e_we   = 1'b1;
            e_lvl  = LVL_ROOT;
            e_data = root_res;
        end
    end

    // Traversal state machine with pruning and result accounting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            a_q        <= '0;
            b_q        <= '0;
            r_q        <= '0;
            root_rem   <= '0;
            root_res   <= '0;
            mid_rem    <= '0;
            mid_res    <= '0;
            cur_m      <= '0;
            cnt        <= '0;
            done       <= 1'b0;
            done_count <= '0;
            done_empty <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        a_q   <= op_a;
                        b_q   <= op_b;
                        r_q   <= op_r;
                        cnt   <= '0;
                        state <= ST_ROOT;
                    end
                end
                ST_ROOT: begin
                    root_rem <= root_a & root_b;
                    root_res <= root_a & root_b;
                    state    <= ST_MID;
                end
                ST_MID: begin
                    if (m_any) begin
                        root_rem[m_pick] <= 1'b0;
                        cur_m            <= m_pick;
                        mid_rem          <= mid_a & mid_b;
                        mid_res          <= mid_a & mid_b;
                        state            <= ST_LEAF;
                    end else begin
                        done       <= 1'b1;
                        done_count <= cnt;
                        done_empty <= (root_res == '0);
                        state      <= ST_IDLE;
                    end
                end
                ST_LEAF: begin
                    if (l_any) begin
                        mid_rem[l_pick] <= 1'b0;
                        if (leaf_and == '0) mid_res[l_pick] <= 1'b0;
                        cnt <= cnt + CW'(leaf_pc);
                    end else begin
                        if (mid_res == '0) root_res[cur_m] <= 1'b0;
                        state <= ST_MID;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // done lasts one cycle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // a start during a run leaves the latched IDs untouched
    p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(a_q) && $stable(b_q) && $stable(r_q)));

    // a zero leaf result prunes its middle bit
    p_zero_leaf_prunes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LEAF && l_any && leaf_and == '0) |=> !mid_res[$past(l_pick)]);

    // empty flag (from the top word) agrees with the leaf count
    p_empty_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (done_empty == (done_count == '0)));

endmodule

// File: rtl/hbl_lane.sv
// Module: top of one hierarchical bitmask intersection lane. Ties the
// domain storage to the traversal engine. Self-contained: no state is
// shared with other lanes. Assumes FAN and NDOM are powers of 2, NDOM >= 2.
module hbl_lane #(
    parameter int FAN  = 16,
    parameter int NDOM = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_level,
    input  logic [$clog2(NDOM)-1:0]   wr_dom,
    input  logic [2*$clog2(FAN)-1:0]  wr_idx,
    input  logic [FAN-1:0]            wr_data,
    input  logic [1:0]                rd_level,
    input  logic [$clog2(NDOM)-1:0]   rd_dom,
    input  logic [2*$clog2(FAN)-1:0]  rd_idx,
    output logic [FAN-1:0]            rd_data,
    input  logic                      start,
    input  logic [$clog2(NDOM)-1:0]   op_a,
    input  logic [$clog2(NDOM)-1:0]   op_b,
    input  logic [$clog2(NDOM)-1:0]   op_r,
    output logic                      busy,
    output logic                      done,
    output logic [3*$clog2(FAN):0]    done_count,
    output logic                      done_empty
);
    localparam int FW = $clog2(FAN);
    localparam int DW = $clog2(NDOM);
    localparam int IW = 2 * FW;

    logic [DW-1:0]  dom_a, dom_b, e_dom;
    logic [FW-1:0]  mid_idx, leaf_idx;
    logic [FAN-1:0] root_a, root_b, mid_a, mid_b, leaf_a, leaf_b, e_data;
    logic           e_we;
    logic [1:0]     e_lvl;
    logic [IW-1:0]  e_idx;

    hbl_store #(.FAN(FAN), .NDOM(NDOM)) u_store (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .h_we(wr_en), .h_lvl(wr_level), .h_dom(wr_dom), .h_idx(wr_idx), .h_data(wr_data),
        .h_rlvl(rd_level), .h_rdom(rd_dom), .h_ridx(rd_idx), .h_rdata(rd_data),
        .e_dom_a(dom_a), .e_dom_b(dom_b), .e_mid_idx(mid_idx), .e_leaf_idx(leaf_idx),
        .root_a(root_a), .root_b(root_b), .mid_a(mid_a), .mid_b(mid_b),
        .leaf_a(leaf_a), .leaf_b(leaf_b),
        .e_we(e_we), .e_lvl(e_lvl), .e_dom(e_dom), .e_idx(e_idx), .e_data(e_data)
    );

    hbl_walker #(.FAN(FAN), .NDOM(NDOM)) u_walker (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .op_r(op_r),
        .busy(busy), .done(done), .done_count(done_count), .done_empty(done_empty),
        .dom_a(dom_a), .dom_b(dom_b), .mid_idx(mid_idx), .leaf_idx(leaf_idx),
        .root_a(root_a), .root_b(root_b), .mid_a(mid_a), .mid_b(mid_b),
        .leaf_a(leaf_a), .leaf_b(leaf_b),
        .e_we(e_we), .e_lvl(e_lvl), .e_dom(e_dom), .e_idx(e_idx), .e_data(e_data)
    );

    // done is only raised once the lane is idle again
    p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/hbl_lane_tb.sv
// Bench: directed corner cases plus seeded random domain pairs, checked
// against a bench model of the storage contents.
module hbl_lane_tb;
    localparam int FAN  = 16;
    localparam int NDOM = 4;
    localparam int FW   = 4;
    localparam int DW   = 2;
    localparam int IW   = 8;
    localparam int NL   = FAN * FAN;
    localparam int CW   = 3 * FW + 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_level = '0;
    logic [DW-1:0]  wr_dom = '0;
    logic [IW-1:0]  wr_idx = '0;
    logic [FAN-1:0] wr_data = '0;
    logic [1:0]     rd_level = '0;
    logic [DW-1:0]  rd_dom = '0;
    logic [IW-1:0]  rd_idx = '0;
    logic [FAN-1:0] rd_data;
    logic           start = 1'b0;
    logic [DW-1:0]  op_a = '0, op_b = '0, op_r = '0;
    logic           busy, done, done_empty;
    logic [CW-1:0]  done_count;

    hbl_lane #(.FAN(FAN), .NDOM(NDOM)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_level(wr_level), .wr_dom(wr_dom), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_level(rd_level), .rd_dom(rd_dom), .rd_idx(rd_idx), .rd_data(rd_data),
        .start(start), .op_a(op_a), .op_b(op_b), .op_r(op_r),
        .busy(busy), .done(done), .done_count(done_count), .done_empty(done_empty)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // storage model and expected result
    logic [FAN-1:0] st_root [NDOM];
    logic [FAN-1:0] st_mid  [NDOM][FAN];
    logic [FAN-1:0] st_leaf [NDOM][NL];
    logic [FAN-1:0] e_root;
    logic [FAN-1:0] e_mid [FAN];
    bit             e_midw [FAN];
    logic [FAN-1:0] e_leaf [NL];
    bit             e_vis [NL];
    int             e_cnt, e_cyc;

    task automatic chk(bit ok, string tag, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // all tasks start and end just after a falling edge
    task automatic wr(logic [1:0] lvl, int d, int idx, logic [FAN-1:0] data);
        wr_en = 1'b1; wr_level = lvl; wr_dom = DW'(d); wr_idx = IW'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] lvl, int d, int idx, output logic [FAN-1:0] data);
        rd_level = lvl; rd_dom = DW'(d); rd_idx = IW'(idx);
        @(negedge clk);
        data = rd_data;
    endtask

    function automatic logic [FAN-1:0] rand_leaf(bit sparse);
        logic [FAN-1:0] w;
        w = FAN'($urandom);
        if (sparse) w = w & FAN'($urandom) & FAN'($urandom);
        if (w == '0) w = FAN'(1) << ($urandom % FAN);
        return w;
    endfunction

    // derive canonical summary words from the leaves
    task automatic rebuild(int d);
        st_root[d] = '0;
        for (int m = 0; m < FAN; m++) begin
            st_mid[d][m] = '0;
            for (int l = 0; l < FAN; l++)
                if (st_leaf[d][m*FAN+l] != '0) st_mid[d][m][l] = 1'b1;
            if (st_mid[d][m] != '0) st_root[d][m] = 1'b1;
        end
    endtask

    task automatic load_dom(int d);
        wr(2'd0, d, 0, st_root[d]);
        for (int m = 0; m < FAN; m++) wr(2'd1, d, m, st_mid[d][m]);
        for (int i = 0; i < NL; i++) wr(2'd2, d, i, st_leaf[d][i]);
    endtask

    task automatic clear_dom(int d);
        for (int i = 0; i < NL; i++) st_leaf[d][i] = '0;
    endtask

    task automatic gen_dom(int d, int pm, int pl, bit sparse);
        clear_dom(d);
        for (int m = 0; m < FAN; m++)
            if (($urandom % 100) < pm)
                for (int l = 0; l < FAN; l++)
                    if (($urandom % 100) < pl) st_leaf[d][m*FAN+l] = rand_leaf(sparse);
        rebuild(d);
        load_dom(d);
    endtask

    // unrelated prior contents for a result domain (not canonical)
    task automatic garbage_dom(int d);
        st_root[d] = FAN'($urandom);
        for (int m = 0; m < FAN; m++) st_mid[d][m] = FAN'($urandom);
        for (int i = 0; i < NL; i++) st_leaf[d][i] = FAN'($urandom);
        load_dom(d);
    endtask

    task automatic compute_exp(int a, int b);
        logic [FAN-1:0] mw, lv;
        e_root = st_root[a] & st_root[b];
        e_cyc = 2;
        e_cnt = 0;
        for (int m = 0; m < FAN; m++) begin
            e_midw[m] = e_root[m];
            e_mid[m] = '0;
            for (int l = 0; l < FAN; l++) begin
                e_vis[m*FAN+l] = 1'b0;
                e_leaf[m*FAN+l] = '0;
            end
            if (e_root[m]) begin
                mw = st_mid[a][m] & st_mid[b][m];
                e_cyc += 2 + $countones(mw);
                for (int l = 0; l < FAN; l++) begin
                    if (mw[l]) begin
                        lv = st_leaf[a][m*FAN+l] & st_leaf[b][m*FAN+l];
                        e_vis[m*FAN+l] = 1'b1;
                        e_leaf[m*FAN+l] = lv;
                        if (lv == '0) mw[l] = 1'b0;
                        e_cnt += $countones(lv);
                    end
                end
                e_mid[m] = mw;
                if (mw == '0) e_root[m] = 1'b0;
            end
        end
    endtask

    task automatic run_op(string tag, int a, int b, int r, bit inject);
        int edges, extra, bad_mid, bad_leaf;
        logic [CW-1:0] got_cnt;
        logic got_empty;
        logic [FAN-1:0] v, ev;
        compute_exp(a, b);
        op_a = DW'(a); op_b = DW'(b); op_r = DW'(r); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        edges = 0;
        if (inject) begin
            // R6/R7: start with other IDs and a host write while busy
            op_a = DW'(b); op_b = DW'(r); op_r = DW'(a); start = 1'b1;
            wr_en = 1'b1; wr_level = 2'd2; wr_dom = DW'(r); wr_idx = IW'(NL - 1);
            wr_data = ~st_leaf[r][NL-1];
        end
        while (1) begin
            @(negedge clk);
            edges++;
            start = 1'b0;
            wr_en = 1'b0;
            if (done || edges > 3000) break;
        end
        got_cnt = done_count;
        got_empty = done_empty;
        chk(done == 1'b1, {tag, " R5 done seen"}, done, 1);
        chk(edges == e_cyc, {tag, " R8 cycles"}, edges, e_cyc);
        chk(got_cnt == CW'(e_cnt), {tag, " R5 count"}, got_cnt, e_cnt);
        chk(got_empty == (e_root == '0), {tag, " R5 empty"}, got_empty, (e_root == '0));
        @(negedge clk);
        chk(done == 1'b0, {tag, " R5 pulse width"}, done, 0);
        extra = 0;
        for (int i = 0; i < 40; i++) begin
            if (done) extra++;
            @(negedge clk);
        end
        chk(extra == 0 && busy == 1'b0, {tag, " R6 no extra run"}, extra, 0);
        // commit expected result into the model
        st_root[r] = e_root;
        for (int m = 0; m < FAN; m++) if (e_midw[m]) st_mid[r][m] = e_mid[m];
        for (int i = 0; i < NL; i++) if (e_vis[i]) st_leaf[r][i] = e_leaf[i];
        rd(2'd0, r, 0, v);
        chk(v == st_root[r], {tag, " R3 top word"}, v, st_root[r]);
        bad_mid = 0;
        for (int m = 0; m < FAN; m++) begin
            rd(2'd1, r, m, v);
            if (v != st_mid[r][m]) begin
                if (bad_mid == 0) $display("  mid %0d got %0h want %0h", m, v, st_mid[r][m]);
                bad_mid++;
            end
        end
        chk(bad_mid == 0, {tag, " R3 R4 middle words"}, bad_mid, 0);
        bad_leaf = 0;
        for (int i = 0; i < NL; i++) begin
            rd(2'd2, r, i, v);
            ev = st_leaf[r][i];
            if (v != ev) begin
                if (bad_leaf == 0) $display("  leaf %0d got %0h want %0h", i, v, ev);
                bad_leaf++;
            end
        end
        chk(bad_leaf == 0, {tag, " R2 R4 R7 leaf words"}, bad_leaf, 0);
    endtask

    initial begin
        logic [FAN-1:0] v;
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        chk(done == 1'b0 && done_empty == 1'b0, "R1 done/empty in reset", {done, done_empty}, 0);
        chk(done_count == '0, "R1 count in reset", done_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 idle after reset", {busy, done}, 0);

        // R10: level codes and registered read
        wr(2'd0, 3, 0, 16'h1234);
        wr(2'd1, 3, 7, 16'hBEEF);
        wr(2'd2, 3, 9*FAN + 2, 16'hC0DE);
        rd(2'd0, 3, 0, v);          chk(v == 16'h1234, "R10 top read", v, 16'h1234);
        rd(2'd1, 3, 7, v);          chk(v == 16'hBEEF, "R10 middle read", v, 16'hBEEF);
        rd(2'd2, 3, 9*FAN + 2, v);  chk(v == 16'hC0DE, "R10 leaf read", v, 16'hC0DE);

        // D1: shared summary bits, disjoint leaves -> full prune, empty
        clear_dom(0); st_leaf[0][3*FAN+5] = 16'h00F0; rebuild(0); load_dom(0);
        clear_dom(1); st_leaf[1][3*FAN+5] = 16'h0F00; rebuild(1); load_dom(1);
        garbage_dom(2);
        run_op("D1 prune cascade", 0, 1, 2, 1'b0);

        // D2: disjoint top words -> nothing visited, with busy injections
        clear_dom(0); st_leaf[0][1*FAN] = 16'h0001; rebuild(0); load_dom(0);
        clear_dom(1); st_leaf[1][2*FAN] = 16'h0001; rebuild(1); load_dom(1);
        garbage_dom(2);
        run_op("D2 top disjoint", 0, 1, 2, 1'b1);

        // D3: identical operands -> copy with full count
        gen_dom(0, 60, 50, 1'b0);
        for (int i = 0; i < NL; i++) st_leaf[1][i] = st_leaf[0][i];
        rebuild(1); load_dom(1);
        garbage_dom(3);
        run_op("D3 identical", 0, 1, 3, 1'b0);

        // D4: R9 result overwrites first operand
        gen_dom(0, 70, 60, 1'b1);
        gen_dom(1, 70, 60, 1'b1);
        run_op("D4 R9 alias", 0, 1, 0, 1'b1);

        // random pairs
        for (int t = 0; t < 18; t++) begin
            int a, b, r;
            a = $urandom % NDOM;
            b = (a + 1 + ($urandom % (NDOM - 1))) % NDOM;
            r = $urandom % NDOM;
            gen_dom(a, 30 + ($urandom % 60), 20 + ($urandom % 60), bit'($urandom % 2));
            gen_dom(b, 30 + ($urandom % 60), 20 + ($urandom % 60), bit'($urandom % 2));
            if (r != a && r != b) garbage_dom(r);
            run_op((r == a || r == b) ? "RND R9" : "RND", a, b, r, bit'($urandom % 2));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule